// File: doc/BRIEF.md
# Integer ALU with overflow trap flag

This is a purely combinational integer arithmetic and logic unit for the execute stage of a small load/store RISC pipeline. It takes two register operands, an optional 16-bit immediate and a 4-bit operation code. It returns a result word, a flag that is high when that word is zero, and a flag that requests an arithmetic-overflow exception.

The B operand comes either from the register port or from the immediate. The block widens the immediate itself, according to the kind of operation. Equal and not-equal branch decisions use the zero flag. The pipeline builds a full 32-bit constant in two steps: an upper-immediate operation, then an OR with the immediate.

Top module: `int_alu`

## Requirements
- R1: Operation codes on `alu_op`: 0 trapping add, 1 wrapping add, 2 trapping subtract (A minus B), 3 wrapping subtract, 4 signed set-less-than, 5 unsigned set-less-than, 6 AND, 7 OR, 8 upper-immediate. Add and subtract results are taken modulo 2^32.
- R2: For codes 0 and 2, `ovf_trap` is high exactly when the true two's-complement sum or difference falls outside the 32-bit signed range.
- R3: Codes 1 and 3 give the same result as codes 0 and 2, and `ovf_trap` stays low for them.
- R4: Code 4 returns 1 when A < B as signed two's-complement numbers, and 0 otherwise.
- R5: Code 5 returns 1 when A < B as unsigned numbers, and 0 otherwise.
- R6: Codes 6 and 7 give the bitwise AND and OR. With `imm_en` high, B is the immediate with zeros in bits 31:16.
- R7: With `imm_en` high and codes 0 to 5, B is the immediate with bit 15 copied into bits 31:16.
- R8: Code 8 returns the immediate in bits 31:16 and zero in bits 15:0, whatever the values of A, B and `imm_en`.
- R9: Feeding the code-8 result back as A to code 7 with the immediate selected gives the full 32-bit constant {upper, lower}.
- R10: `res_zero` is high exactly when `res` is all zeros.
- R11: Codes 9 to 15 give `res` = 0 and `ovf_trap` low.
- R12: `ovf_trap` is low for every code other than 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 4 | Operation code |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B from the register port |
| imm | input | 16 | Immediate field |
| imm_en | input | 1 | Select the extended immediate as B |
| res | output | 32 | Result word |
| res_zero | output | 1 | Result equals zero |
| ovf_trap | output | 1 | Signed overflow exception request |

## Verification
The add and subtract paths are driven at the signed range limits: the largest positive value plus one, the most negative value minus one, and mixed-sign pairs. Together these separate a correct overflow rule from a carry-out rule or a missing subtract inversion, and they confirm that the wrapping forms never flag. The compare codes are given pairs such as -1 against 1, where the signed and unsigned answers differ, and operand pairs whose difference overflows, where taking the sign bit of the difference gives the wrong answer. All-ones immediates separate zero extension from sign extension. A chained upper-immediate then OR sequence checks constant building. Several thousand pseudo-random vectors over all sixteen codes cover the remaining cases.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int DW = 32
) (
  input  logic [3:0]      alu_op,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [DW/2-1:0] imm,
  input  logic            imm_en,
  output logic [DW-1:0]   res,
  output logic            res_zero,
  output logic            ovf_trap
);
  localparam int IW = DW / 2;
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDU = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBU = 4'd3;
  localparam logic [3:0] OP_SLT  = 4'd4;
  localparam logic [3:0] OP_SLTU = 4'd5;
  localparam logic [3:0] OP_AND  = 4'd6;
  localparam logic [3:0] OP_OR   = 4'd7;
  localparam logic [3:0] OP_LUI  = 4'd8;

  logic          is_logic, is_sub, sign_ovf;
  logic [DW-1:0] imm_ext, b_eff, b_add;
  logic [DW:0]   sum;

  assign is_logic = (alu_op == OP_AND) || (alu_op == OP_OR);
  assign is_sub   = (alu_op == OP_SUB) || (alu_op == OP_SUBU) ||
                    (alu_op == OP_SLT) || (alu_op == OP_SLTU);
  assign imm_ext  = is_logic ? {{IW{1'b0}}, imm} : {{IW{imm[IW-1]}}, imm};
  assign b_eff    = imm_en ? imm_ext : opb;
  assign b_add    = is_sub ? ~b_eff : b_eff;
  assign sum      = {1'b0, opa} + {1'b0, b_add} + {{DW{1'b0}}, is_sub};
  assign sign_ovf = (opa[DW-1] == b_add[DW-1]) && (sum[DW-1] != opa[DW-1]);

  always_comb begin
    res      = '0;
    ovf_trap = 1'b0;
    case (alu_op)
      OP_ADD, OP_SUB: begin
        res      = sum[DW-1:0];
        ovf_trap = sign_ovf;
      end
      OP_ADDU, OP_SUBU: res = sum[DW-1:0];
      OP_SLT:  res = {{(DW-1){1'b0}}, sum[DW-1] ^ sign_ovf};
      OP_SLTU: res = {{(DW-1){1'b0}}, ~sum[DW]};
      OP_AND:  res = opa & b_eff;
      OP_OR:   res = opa | b_eff;
      OP_LUI:  res = {imm, {IW{1'b0}}};
      default: ;
    endcase
  end

  assign res_zero = ~|res;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int DW = 32
) (
  input logic [3:0]      alu_op,
  input logic [DW/2-1:0] imm,
  input logic [DW-1:0]   res,
  input logic            ovf_trap
);
  localparam int IW = DW / 2;

  always_comb begin
    // R3
    no_overflow_chk: assert (!((alu_op == 4'd1 || alu_op == 4'd3) && ovf_trap));
    // R12
    trap_source_chk: assert (!ovf_trap || alu_op == 4'd0 || alu_op == 4'd2);
    // R4
    slt_width_chk: assert (!(alu_op == 4'd4 || alu_op == 4'd5) || res[DW-1:1] == '0);
    // R8
    upper_imm_chk: assert (alu_op != 4'd8 || (res[IW-1:0] == '0 && res[DW-1:IW] == imm));
    // R11
    unknown_code_chk: assert (alu_op <= 4'd8 || (res == '0 && !ovf_trap));
  end
endmodule

bind int_alu int_alu_chk #(.DW(DW)) chk_i (
  .alu_op(alu_op), .imm(imm), .res(res), .ovf_trap(ovf_trap)
);

// File: tb/int_alu_tb.sv
module int_alu_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  alu_op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic        imm_en = 1'b0;
  logic [31:0] res;
  logic        res_zero, ovf_trap;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit done = 1'b0;

  int_alu dut_i (
    .alu_op(alu_op), .opa(opa), .opb(opb), .imm(imm), .imm_en(imm_en),
    .res(res), .res_zero(res_zero), .ovf_trap(ovf_trap)
  );

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic en,
                       output logic [31:0] er, output logic eo);
    logic [31:0] bv;
    longint sa, sb, s;
    if (en) bv = (op == 4'd6 || op == 4'd7) ? {16'h0, im} : {{16{im[15]}}, im};
    else    bv = b;
    sa = longint'($signed(a));
    sb = longint'($signed(bv));
    er = '0;
    eo = 1'b0;
    case (op)
      4'd0: begin s = sa + sb; er = s[31:0]; eo = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd1: er = a + bv;
      4'd2: begin s = sa - sb; er = s[31:0]; eo = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd3: er = a - bv;
      4'd4: er = (sa < sb) ? 32'd1 : 32'd0;
      4'd5: er = (longint'({32'h0, a}) < longint'({32'h0, bv})) ? 32'd1 : 32'd0;
      4'd6: er = a & bv;
      4'd7: er = a | bv;
      4'd8: er = {im, 16'h0};
      default: er = '0;
    endcase
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic en, input string tag);
    logic [31:0] er;
    logic eo;
    @(posedge clk);
    alu_op = op; opa = a; opb = b; imm = im; imm_en = en;
    model(op, a, b, im, en, er, eo);
    @(negedge clk);
    vec_cnt++;
    if (res !== er || ovf_trap !== eo || res_zero !== (er == 32'h0)) begin
      err_cnt++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h en=%0b: res=%h ovf=%0b zero=%0b expected res=%h ovf=%0b zero=%0b",
               tag, op, a, b, im, en, res, ovf_trap, res_zero, er, eo, (er == 32'h0));
    end
  endtask

  initial begin
    logic [31:0] upper;
    apply(4'd0, 32'h0, 32'h0, 16'h0, 1'b0, "R10 all-zero");
    apply(4'd0, 32'h7fffffff, 32'h1, 16'h0, 1'b0, "R2 pos overflow");
    apply(4'd2, 32'h80000000, 32'h1, 16'h0, 1'b0, "R2 neg overflow");
    apply(4'd2, 32'h00000001, 32'h80000000, 16'h0, 1'b0, "R2 sub overflow");
    apply(4'd0, 32'hffffffff, 32'h1, 16'h0, 1'b0, "R2 carry no ovf");
    apply(4'd1, 32'h7fffffff, 32'h1, 16'h0, 1'b0, "R3 addu wraps");
    apply(4'd3, 32'h80000000, 32'h1, 16'h0, 1'b0, "R3 subu wraps");
    apply(4'd2, 32'h1234abcd, 32'h1234abcd, 16'h0, 1'b0, "R10 equal sub");
    apply(4'd4, 32'hffffffff, 32'h1, 16'h0, 1'b0, "R4 -1<1");
    apply(4'd4, 32'h80000000, 32'h1, 16'h0, 1'b0, "R4 ovf compare");
    apply(4'd4, 32'h7fffffff, 32'hffffffff, 16'h0, 1'b0, "R4 max vs -1");
    apply(4'd5, 32'hffffffff, 32'h1, 16'h0, 1'b0, "R5 unsigned big");
    apply(4'd5, 32'h1, 32'hffffffff, 16'h0, 1'b0, "R5 unsigned small");
    apply(4'd0, 32'h5, 32'h0, 16'hffff, 1'b1, "R7 sign-ext add");
    apply(4'd4, 32'h0, 32'h0, 16'hffff, 1'b1, "R7 sign-ext slt");
    apply(4'd7, 32'h0, 32'h0, 16'hffff, 1'b1, "R6 zero-ext or");
    apply(4'd6, 32'hffffffff, 32'h0, 16'h8001, 1'b1, "R6 zero-ext and");
    apply(4'd6, 32'hf0f0f0f0, 32'h3c3c3c3c, 16'h0, 1'b0, "R6 and reg");
    apply(4'd8, 32'hdeadbeef, 32'h5555aaaa, 16'habcd, 1'b0, "R8 lui");
    upper = res;
    apply(4'd7, upper, 32'h0, 16'h1234, 1'b1, "R9 lui then or");
    if (res !== 32'habcd1234) begin
      err_cnt++;
      $display("FAIL R9 constant res=%h expected res=%h", res, 32'habcd1234);
    end
    vec_cnt++;
    apply(4'd12, 32'hffffffff, 32'hffffffff, 16'hffff, 1'b1, "R11 unknown");
    apply(4'd15, 32'h7fffffff, 32'h1, 16'h0, 1'b0, "R11 unknown 15");
    for (int i = 0; i < 3000; i++)
      apply(4'($urandom_range(0, 15)), $urandom, $urandom, 16'($urandom), 1'($urandom),
            "R1 random");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule